// File: doc/BRIEF.md
# Multi-Mode 8-Bit Pulse Timer

This block is an 8-bit counter shared by three kinds of work. As a down-counter it either fires once or runs as a periodic square-wave source. As an up-counter it measures the time between two chosen edges of a sampled input, with an option to measure again and again without software involvement. Its count clock is the system clock, the system clock divided by 4 or by 32, or the rising edges of an external clock pin.

Software picks a mode and a clock source, writes a reload value and raises the run bit. The run bit is a level: its rising edge (re)initialises the timer and its low level halts it. The interrupt flag is set on every underflow and on every capture, and is cleared by a one-cycle clear pulse. Both the external clock and the measured signal are asynchronous. Each is passed through two flip-flops and then edge-detected, so an edge on either pin acts on the third rising clock edge after it appears.

Top module: `pwt_timer8`

## Requirements
- R1: After reset, countVal, captureVal, timerOut, irqFlag and ovfFlag are all 0.
- R2: The count tick is selected by clkSel. The value 0 ticks every cycle. The value 1 ticks every 4th cycle and 2 every 32nd cycle, both counted from the start edge of startEn, so the first tick acts on the 4th or 32nd clock edge after it. The value 3 ticks once per synchronised rising edge of extClk, whatever the length of its high phase.
- R3: One-shot (modeSel 0). A rising edge of startEn loads reloadVal and sets timerOut to 1. Each tick decrements the counter. A tick at count 0 clears timerOut and sets irqFlag, and the timer then stays halted until startEn falls and rises again.
- R4: Reload (modeSel 1). A rising edge of startEn loads reloadVal and clears timerOut. A tick at count 0 reloads reloadVal, toggles timerOut and sets irqFlag, so timerOut has a half period of reloadVal+1 ticks.
- R5: Measurement edge pairs (start edge, end edge) are as follows. modeSel 2 measures rise to fall. modeSel 3 measures fall to rise. modeSel 4 measures rise to rise. modeSel 5 measures fall to fall. modeSel 6 measures from any edge to the next edge. A rising edge of startEn clears the counter and arms the timer, and the start edge clears the counter again.
- R6: At the end edge, captureVal takes the number of ticks from the start edge up to and including the end-edge cycle, and irqFlag is set. With clkSel 0, a phase of N cycles yields N.
- R7: A tick while the measuring counter is 0xFF sets ovfFlag and leaves the counter at 0xFF, so an over-long interval captures 0xFF (an interval of 256 cycles already does). ovfFlag is cleared by a rising edge of startEn or by irqClr.
- R8: With contMode 1, the timer re-arms after each capture. In modes 4 to 6 the end edge starts the next interval. In modes 2 and 3 it waits for the next start edge, with the counter held at 0 and ticks ignored. With contMode 0, it halts after one capture, and later edges change neither captureVal nor irqFlag.
- R9: irqClr clears irqFlag, but when an event sets the flag in the same cycle the set wins.
- R10: While startEn is 0, countVal, captureVal and timerOut hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Operating mode (0 one-shot, 1 reload, 2 to 6 measurement, 7 inert) |
| clkSel | input | 2 | Tick source (0 /1, 1 /4, 2 /32, 3 external) |
| reloadVal | input | 8 | Down-count start value |
| startEn | input | 1 | Run bit; rising edge starts, low halts |
| contMode | input | 1 | Continuous measurement enable |
| irqClr | input | 1 | One-cycle interrupt and overflow clear |
| extClk | input | 1 | Asynchronous external count clock |
| sigIn | input | 1 | Asynchronous signal being measured |
| countVal | output | 8 | Current counter value |
| captureVal | output | 8 | Last captured interval |
| timerOut | output | 1 | Underflow / square-wave output |
| irqFlag | output | 1 | Interrupt request flag |
| ovfFlag | output | 1 | Measurement overflow flag |

## Verification
Two events can land on the same clock edge. In the first, an underflow sets the interrupt flag in the cycle in which software pulses irqClr. The bench times the clear pulse onto the underflow edge and expects irqFlag to read 1 afterwards, and then expects a lone clear to drop it. In the second, an end edge coincides with a count tick, which with the every-cycle tick is always the case. The bench checks that the captured width equals the phase length exactly, including the boundary where a 255-cycle pulse captures 255 without overflow and a 256-cycle pulse captures 0xFF with ovfFlag set.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_RELOAD  = 3'd1,
    MODE_HIGH    = 3'd2,
    MODE_LOW     = 3'd3,
    MODE_RISE    = 3'd4,
    MODE_FALL    = 3'd5,
    MODE_BOTH    = 3'd6,
    MODE_NONE    = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ARM   = 2'd2,
    ST_MEAS  = 2'd3
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRel;
    logic clrCnt;
    logic decCnt;
    logic incCnt;
    logic capture;
    logic capBump;
    logic setIrq;
    logic setOvf;
    logic clrOvf;
    logic outSet;
    logic outClr;
    logic outTgl;
  } strobe_t;

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int MID_DIV  = 4,
  parameter int SLOW_DIV = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic [1:0]       clkSel,
  input  logic             startEn,
  input  logic             contMode,
  input  logic             extClk,
  input  logic             sigIn,
  input  logic [WIDTH-1:0] countVal,
  output strobe_t          strb
);
  localparam int MIDW  = $clog2(MID_DIV);
  localparam int SLOWW = $clog2(SLOW_DIV);

  mode_e  modeNow;
  state_e state, stateNext;
  logic   startPrev, startRise;
  logic   extRise, extFall, sigRise, sigFall;
  logic   tick, startEdge, endEdge, periodic;
  logic   cntZero, cntFull;
  logic [SLOWW-1:0] divCnt;

  assign modeNow   = mode_e'(modeSel);
  assign startRise = startEn & ~startPrev;
  assign cntZero   = (countVal == '0);
  assign cntFull   = &countVal;

  pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extClk), .rise(extRise), .fall(extFall));
  pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sigSync (
    .clk(clk), .rstN(rstN), .din(sigIn), .rise(sigRise), .fall(sigFall));

  // prescaler, restarted by the start edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      startPrev <= 1'b0;
      state     <= ST_IDLE;
    end else begin
      divCnt    <= startRise ? '0 : divCnt + 1'b1;
      startPrev <= startEn;
      state     <= stateNext;
    end
  end

  always_comb begin
    unique case (clkSel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = &divCnt[MIDW-1:0];
      2'd2:    tick = &divCnt;
      default: tick = extRise & ~extFall;
    endcase
  end

  always_comb begin
    startEdge = 1'b0;
    endEdge   = 1'b0;
    periodic  = 1'b0;
    unique case (modeNow)
      MODE_HIGH: begin startEdge = sigRise; endEdge = sigFall; end
      MODE_LOW:  begin startEdge = sigFall; endEdge = sigRise; end
      MODE_RISE: begin startEdge = sigRise; endEdge = sigRise; periodic = 1'b1; end
      MODE_FALL: begin startEdge = sigFall; endEdge = sigFall; periodic = 1'b1; end
      MODE_BOTH: begin
        startEdge = sigRise | sigFall;
        endEdge   = sigRise | sigFall;
        periodic  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (!startEn) begin
      stateNext = ST_IDLE;
    end else if (startRise) begin
      strb.clrOvf = 1'b1;
      unique case (modeNow)
        MODE_ONESHOT: begin strb.loadRel = 1'b1; strb.outSet = 1'b1; stateNext = ST_COUNT; end
        MODE_RELOAD:  begin strb.loadRel = 1'b1; strb.outClr = 1'b1; stateNext = ST_COUNT; end
        MODE_NONE:    stateNext = ST_IDLE;
        default:      begin strb.clrCnt = 1'b1; strb.outClr = 1'b1; stateNext = ST_ARM; end
      endcase
    end else begin
      unique case (state)
        ST_COUNT: if (tick) begin
          if (cntZero) begin
            strb.setIrq = 1'b1;
            if (modeNow == MODE_ONESHOT) begin
              strb.outClr = 1'b1;
              stateNext   = ST_IDLE;
            end else begin
              strb.loadRel = 1'b1;
              strb.outTgl  = 1'b1;
            end
          end else begin
            strb.decCnt = 1'b1;
          end
        end
        ST_ARM: if (startEdge) begin
          strb.clrCnt = 1'b1;
          stateNext   = ST_MEAS;
        end
        ST_MEAS: begin
          if (endEdge) begin
            strb.capture = 1'b1;
            strb.setIrq  = 1'b1;
            strb.clrCnt  = 1'b1;
            if (tick) begin
              if (cntFull) strb.setOvf  = 1'b1;
              else         strb.capBump = 1'b1;
            end
            if (!contMode)     stateNext = ST_IDLE;
            else if (periodic) stateNext = ST_MEAS;
            else               stateNext = ST_ARM;
          end else if (tick) begin
            if (cntFull) strb.setOvf = 1'b1;
            else         strb.incCnt = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: while armed and waiting, the counter sits at zero
  p_arm_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ARM |-> countVal == '0);

endmodule

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] reloadVal,
  input  logic             irqClr,
  output logic [WIDTH-1:0] countVal,
  output logic [WIDTH-1:0] captureVal,
  output logic             timerOut,
  output logic             irqFlag,
  output logic             ovfFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal   <= '0;
      captureVal <= '0;
      timerOut   <= 1'b0;
      irqFlag    <= 1'b0;
      ovfFlag    <= 1'b0;
    end else begin
      if (strb.loadRel)     countVal <= reloadVal;
      else if (strb.clrCnt) countVal <= '0;
      else if (strb.decCnt) countVal <= countVal - 1'b1;
      else if (strb.incCnt) countVal <= countVal + 1'b1;

      if (strb.capture)
        captureVal <= strb.capBump ? WIDTH'(countVal + 1'b1) : countVal;

      if (strb.outSet)      timerOut <= 1'b1;
      else if (strb.outClr) timerOut <= 1'b0;
      else if (strb.outTgl) timerOut <= ~timerOut;

      if (strb.setIrq)   irqFlag <= 1'b1;
      else if (irqClr)   irqFlag <= 1'b0;

      if (strb.setOvf)                    ovfFlag <= 1'b1;
      else if (strb.clrOvf || irqClr)     ovfFlag <= 1'b0;
    end
  end

  // R9: a set request beats a simultaneous clear
  p_irq_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIrq |=> irqFlag);

  // R7: a clear with no set leaves the overflow flag low
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrOvf && !strb.setOvf) |=> !ovfFlag);

endmodule

// File: rtl/pwt_timer8.sv
module pwt_timer8
  import pwt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int MID_DIV     = 4,
  parameter int SLOW_DIV    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic [1:0]       clkSel,
  input  logic [WIDTH-1:0] reloadVal,
  input  logic             startEn,
  input  logic             contMode,
  input  logic             irqClr,
  input  logic             extClk,
  input  logic             sigIn,
  output logic [WIDTH-1:0] countVal,
  output logic [WIDTH-1:0] captureVal,
  output logic             timerOut,
  output logic             irqFlag,
  output logic             ovfFlag
);
  strobe_t strb;

  pwt_ctrl #(
    .WIDTH(WIDTH), .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .clkSel(clkSel),
    .startEn(startEn), .contMode(contMode), .extClk(extClk), .sigIn(sigIn),
    .countVal(countVal), .strb(strb));

  pwt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal), .irqClr(irqClr),
    .countVal(countVal), .captureVal(captureVal), .timerOut(timerOut),
    .irqFlag(irqFlag), .ovfFlag(ovfFlag));

  // R10: a halted timer keeps its count
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |=> $stable(countVal) && $stable(timerOut));

  // R6: every new capture comes with a raised interrupt
  p_cap_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(captureVal) |-> irqFlag);

  // R3: the one-shot output only drops at underflow
  p_oneshot_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && $fell(timerOut)) |-> irqFlag);

  // R7: overflow appears only with a saturated count or capture
  p_ovf_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (countVal == '1 || captureVal == '1));

endmodule

// File: tb/test_pwt_timer8.sv
`timescale 1ns/1ps
module test_pwt_timer8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = '0;
  logic [1:0] clkSel = '0;
  logic [7:0] reloadVal = '0;
  logic       startEn = 1'b0, contMode = 1'b0, irqClr = 1'b0;
  logic       extClk = 1'b0, sigIn = 1'b0;
  logic [7:0] countVal, captureVal;
  logic       timerOut, irqFlag, ovfFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwt_timer8 i_pwt_timer8 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .clkSel(clkSel),
    .reloadVal(reloadVal), .startEn(startEn), .contMode(contMode),
    .irqClr(irqClr), .extClk(extClk), .sigIn(sigIn),
    .countVal(countVal), .captureVal(captureVal), .timerOut(timerOut),
    .irqFlag(irqFlag), .ovfFlag(ovfFlag));

  typedef struct packed {
    logic [2:0] mode;
    logic       idle;
    logic [9:0] len1;
    logic [9:0] len2;
    logic [7:0] expCap;
    logic       expOvf;
  } vec_t;

  // measurement vectors (R5, R6, R7); last row is a 1-cycle high pulse
  localparam vec_t VECS [9] = '{
    '{3'd2, 1'b0, 10'd5,   10'd4,   8'd5,   1'b0},
    '{3'd3, 1'b1, 10'd7,   10'd3,   8'd7,   1'b0},
    '{3'd4, 1'b0, 10'd3,   10'd6,   8'd9,   1'b0},
    '{3'd5, 1'b1, 10'd4,   10'd2,   8'd6,   1'b0},
    '{3'd6, 1'b0, 10'd6,   10'd9,   8'd6,   1'b0},
    '{3'd2, 1'b0, 10'd255, 10'd4,   8'd255, 1'b0},
    '{3'd2, 1'b0, 10'd256, 10'd4,   8'd255, 1'b1},
    '{3'd4, 1'b0, 10'd200, 10'd100, 8'd255, 1'b1},
    '{3'd2, 1'b0, 10'd1,   10'd4,   8'd1,   1'b0}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stopClr();
    startEn = 1'b0;
    irqClr  = 1'b1;
    cyc(1);
    irqClr  = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    check("R1", "count",   countVal,   0);
    check("R1", "capture", captureVal, 0);
    check("R1", "out",     timerOut,   0);
    check("R1", "irq",     irqFlag,    0);
    check("R1", "ovf",     ovfFlag,    0);

    // measurement vector table
    foreach (VECS[i]) begin
      stopClr();
      modeSel = VECS[i].mode;
      contMode = 1'b0;
      clkSel = 2'd0;
      sigIn = VECS[i].idle;
      cyc(4);
      startEn = 1'b1;
      cyc(3);
      check("R8", "armed count", countVal, 0);
      sigIn = ~VECS[i].idle;
      cyc(int'(VECS[i].len1));
      sigIn = VECS[i].idle;
      cyc(int'(VECS[i].len2));
      sigIn = ~VECS[i].idle;
      cyc(6);
      check("R5/R6", $sformatf("row %0d capture", i), captureVal, VECS[i].expCap);
      check("R7", $sformatf("row %0d ovf", i), ovfFlag, VECS[i].expOvf);
      check("R6", $sformatf("row %0d irq", i), irqFlag, 1);
    end

    // single-shot measurement ignores later pulses (R8)
    irqClr = 1'b1; cyc(1); irqClr = 1'b0;
    sigIn = 1'b0; cyc(3);
    sigIn = 1'b1; cyc(9);
    sigIn = 1'b0; cyc(4);
    check("R8", "halted capture", captureVal, 1);
    check("R8", "halted irq", irqFlag, 0);

    // one-shot, every-cycle tick (R3)
    stopClr();
    modeSel = 3'd0; clkSel = 2'd0; reloadVal = 8'd5;
    startEn = 1'b1;
    cyc(1);
    check("R3", "loaded count", countVal, 5);
    check("R3", "out high", timerOut, 1);
    cyc(5);
    check("R3", "count at zero", countVal, 0);
    check("R3", "out before underflow", timerOut, 1);
    cyc(1);
    check("R3", "out after underflow", timerOut, 0);
    check("R3", "irq at underflow", irqFlag, 1);
    cyc(5);
    check("R3", "halted out", timerOut, 0);
    check("R3", "halted count", countVal, 0);

    // underflow and clear on the same edge (R9)
    stopClr();
    startEn = 1'b1;
    cyc(6);
    irqClr = 1'b1;
    cyc(1);
    irqClr = 1'b0;
    check("R9", "set beats clear", irqFlag, 1);
    irqClr = 1'b1; cyc(1); irqClr = 1'b0;
    check("R9", "lone clear", irqFlag, 0);

    // halt holds the count (R10)
    stopClr();
    reloadVal = 8'd20;
    startEn = 1'b1;
    cyc(4);
    check("R10", "running count", countVal, 17);
    startEn = 1'b0;
    cyc(5);
    check("R10", "held count", countVal, 17);
    check("R10", "held out", timerOut, 1);

    // reload square wave (R4)
    stopClr();
    modeSel = 3'd1; reloadVal = 8'd3;
    startEn = 1'b1;
    cyc(1);
    check("R4", "loaded count", countVal, 3);
    check("R4", "out low", timerOut, 0);
    cyc(3);
    check("R4", "before toggle", timerOut, 0);
    cyc(1);
    check("R4", "first toggle", timerOut, 1);
    check("R4", "reloaded", countVal, 3);
    check("R4", "irq", irqFlag, 1);
    cyc(4);
    check("R4", "second toggle", timerOut, 0);

    // divide-by-4 tick (R2)
    stopClr();
    modeSel = 3'd0; clkSel = 2'd1; reloadVal = 8'd2;
    startEn = 1'b1;
    cyc(12);
    check("R2", "div4 before", timerOut, 1);
    cyc(1);
    check("R2", "div4 underflow", timerOut, 0);

    // divide-by-32 tick (R2)
    stopClr();
    clkSel = 2'd2; reloadVal = 8'd0;
    startEn = 1'b1;
    cyc(32);
    check("R2", "div32 before", timerOut, 1);
    cyc(1);
    check("R2", "div32 underflow", timerOut, 0);

    // external clock tick (R2)
    stopClr();
    clkSel = 2'd3; reloadVal = 8'd1;
    startEn = 1'b1;
    cyc(1);
    extClk = 1'b1; cyc(4);
    check("R2", "ext one tick", countVal, 0);
    check("R2", "ext out", timerOut, 1);
    extClk = 1'b0; cyc(3);
    extClk = 1'b1; cyc(4);
    check("R2", "ext underflow", timerOut, 0);
    check("R2", "ext irq", irqFlag, 1);
    extClk = 1'b0;

    // continuous rise-to-rise (R8)
    stopClr();
    modeSel = 3'd4; clkSel = 2'd0; contMode = 1'b1; sigIn = 1'b0;
    cyc(4);
    startEn = 1'b1; cyc(3);
    sigIn = 1'b1; cyc(3);
    sigIn = 1'b0; cyc(5);
    sigIn = 1'b1; cyc(4);
    check("R8", "period one", captureVal, 8);
    sigIn = 1'b0; cyc(8);
    sigIn = 1'b1; cyc(4);
    check("R8", "period two", captureVal, 12);

    // continuous high width (R8)
    stopClr();
    modeSel = 3'd2; sigIn = 1'b0;
    cyc(4);
    startEn = 1'b1; cyc(3);
    sigIn = 1'b1; cyc(4);
    sigIn = 1'b0; cyc(6);
    check("R8", "width one", captureVal, 4);
    check("R8", "rearmed count", countVal, 0);
    sigIn = 1'b1; cyc(7);
    sigIn = 1'b0; cyc(4);
    check("R8", "width two", captureVal, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule